// File: doc/BRIEF.md
# Countdown Watchdog Timer with Register Window

This block is a watchdog peripheral that software reaches through a small byte-addressed register window. A 16-bit count register holds the value the countdown restarts from. An 8-bit control/status register turns the countdown on and off, requests a restart of the countdown, enables a non-maskable interrupt pulse, and reports expiry through a sticky warning flag. The countdown moves down by one on each cycle in which the tick enable input is high. The system provides that input at a 10 ms rate, so 100 ticks make one second and the longest timeout is 65535 ticks.

To arm the watchdog, software writes the timeout in ticks to the count register. It then writes the control byte with both the enable bit and the reload bit set. To keep the watchdog alive, software writes the same control byte again before the count runs out. A read of the count register returns the ticks still remaining. If the count reaches zero while the watchdog is enabled, the block sets the warning flag, pulses the interrupt output when that output is enabled, and holds the system reset output high for a fixed number of clock cycles.

Top module: `wdog_timer`

## Requirements
- R1: After synchronous reset, the count register reads 0, the control register reads 0x00, and both rst_out and nmi_out are low.
- R2: A write to offset 0x10 stores the reload value and leaves the live countdown unchanged. A read of offset 0x10 always returns the live countdown.
- R3: At offset 0x16, control bit 0 is enable and bit 3 is NMI enable, and both read back as written. Bit 7 reads as the warning flag. Bit 2 (reload) and bits 1, 4, 5 and 6 always read 0.
- R4: A control write with bit 0 and bit 2 both set loads the live countdown from the stored reload value. This load takes priority over a tick in the same cycle.
- R5: While enabled, the live countdown falls by exactly one on each clock with tick_en high. It holds on clocks without a tick, and it holds at 0.
- R6: When enable is 0, the countdown stays frozen and no expiry occurs, whatever tick_en does.
- R7: Expiry happens when a tick arrives while the countdown is enabled and at 1. On that clock edge the countdown becomes 0 and the warning flag is set. A countdown that is already at 0 does not expire again.
- R8: On expiry, rst_out goes high at that same edge and stays high for exactly RST_CYCLES clocks.
- R9: On expiry, nmi_out is high for exactly one clock if NMI enable is set. It stays low if NMI enable is clear.
- R10: Writing 1 to control bit 7 clears the warning flag, and writing 0 there leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R11: A control write with bit 2 set and bit 0 clear does not change the live countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle clock enable marking a 10 ms tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset into the register window |
| bus_wdata | input | 16 | Write data (the control write uses bits 7:0) |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| rst_out | output | 1 | System reset request |
| nmi_out | output | 1 | Non-maskable interrupt pulse |

## Verification
A corrupted live countdown shows up on the very next read of offset 0x10. It also moves the expiry edge, and the bench measures that edge to the tick by watching rst_out. A stuck enable or warning bit shows up as a wrong control byte on the next read, or as a reset that arrives or fails to arrive on the expected tick. A wrong length for the reset-pulse counter is visible as a rst_out width other than RST_CYCLES, measured cycle by cycle right after expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h16;

    localparam int B_EN   = 0;
    localparam int B_LOAD = 2;
    localparam int B_NMI  = 3;
    localparam int B_WARN = 7;

    typedef struct packed {
        logic warn;
        logic nmi_en;
        logic en;
    } ctl_state_t;

    function automatic logic [7:0] ctl_byte(input ctl_state_t s);
        logic [7:0] b;
        b         = 8'h00;
        b[B_EN]   = s.en;
        b[B_NMI]  = s.nmi_en;
        b[B_WARN] = s.warn;
        return b;
    endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] INIT_RELOAD = 16'd3000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic              expire,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic [CNT_W-1:0]  reload_val,
    output ctl_state_t        ctl,
    output logic              load_req,
    output logic [CNT_W-1:0]  bus_rdata
);
    logic wr_cnt, wr_ctl, warn_clr;

    assign wr_cnt   = bus_wr && (bus_addr == OFS_COUNT);
    assign wr_ctl   = bus_wr && (bus_addr == OFS_CTRL);
    assign warn_clr = wr_ctl && bus_wdata[B_WARN];
    assign load_req = wr_ctl && bus_wdata[B_EN] && bus_wdata[B_LOAD];

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_val <= INIT_RELOAD;
            ctl        <= '0;
        end else begin
            if (wr_cnt) reload_val <= bus_wdata;
            if (wr_ctl) begin
                ctl.en     <= bus_wdata[B_EN];
                ctl.nmi_en <= bus_wdata[B_NMI];
            end
            if (expire)        ctl.warn <= 1'b1;
            else if (warn_clr) ctl.warn <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_COUNT)     bus_rdata = live_cnt;
        else if (bus_addr == OFS_CTRL) bus_rdata = {{(CNT_W-8){1'b0}}, ctl_byte(ctl)};
    end

    AST_WARN_STICKY: assert property (@(posedge clk) disable iff (rst)
        ctl.warn && !warn_clr |=> ctl.warn) else $error("warn lost"); // R10
    AST_WARN_SET: assert property (@(posedge clk) disable iff (rst)
        expire |=> ctl.warn) else $error("warn not set"); // R7
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;
    assign step   = en && tick && (cnt != '0);
    assign expire = step && !load && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (step) cnt <= cnt - ONE;
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val)) else $error("load"); // R4
    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en && !load |=> $stable(cnt)) else $error("frozen"); // R6
    AST_DOWN_ONE: assert property (@(posedge clk) disable iff (rst)
        en && tick && !load && cnt != '0 |=> cnt == $past(cnt) - ONE) else $error("step"); // R5
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic nmi_en,
    output logic rst_out,
    output logic nmi_out
);
    localparam int RW = $clog2(RST_CYCLES + 1);

    logic [RW-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold    <= '0;
            nmi_out <= 1'b0;
        end else begin
            nmi_out <= expire && nmi_en;
            if (expire)         hold <= RW'(RST_CYCLES);
            else if (hold != 0) hold <= hold - 1'b1;
        end
    end

    assign rst_out = (hold != '0);

    AST_RST_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        expire |=> rst_out) else $error("no reset"); // R8
    AST_NMI_ONE: assert property (@(posedge clk) disable iff (rst)
        nmi_out |=> !nmi_out) else $error("nmi wide"); // R9
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int RST_CYCLES = 8,
    parameter logic [CNT_W-1:0] INIT_RELOAD = 16'd3000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              rst_out,
    output logic              nmi_out
);
    logic [CNT_W-1:0] reload_val, live_cnt;
    logic             load_req, expire;
    ctl_state_t       ctl;

    wdt_regs #(.CNT_W(CNT_W), .INIT_RELOAD(INIT_RELOAD)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .expire(expire), .live_cnt(live_cnt),
        .reload_val(reload_val), .ctl(ctl), .load_req(load_req),
        .bus_rdata(bus_rdata)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .en(ctl.en), .tick(tick_en),
        .load(load_req), .load_val(reload_val),
        .cnt(live_cnt), .expire(expire)
    );

    wdt_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
        .clk(clk), .rst(rst), .expire(expire), .nmi_en(ctl.nmi_en),
        .rst_out(rst_out), .nmi_out(nmi_out)
    );

    AST_NO_EXPIRE_OFF: assert property (@(posedge clk) disable iff (rst)
        !ctl.en |=> !nmi_out) else $error("nmi while off"); // R6
endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
    localparam int RC = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = 5'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        rst_out, nmi_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wdog_timer #(.RST_CYCLES(RC)) i_wdog_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_out(rst_out), .nmi_out(nmi_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(5'h10, d); check("R1 count", d, 0);
        rd(5'h16, d); check("R1 ctrl", d, 0);
        check("R1 rst_out", rst_out, 0);
        check("R1 nmi_out", nmi_out, 0);
    endtask

    task automatic t_arm_count();
        logic [15:0] d;
        wr(5'h10, 16'd5);
        rd(5'h10, d); check("R2 live unchanged by count write", d, 0);
        wr(5'h16, 16'h04);
        rd(5'h10, d); check("R11 reload without enable", d, 0);
        wr(5'h16, 16'h05);
        rd(5'h10, d); check("R4 load on enable+reload", d, 5);
        rd(5'h16, d); check("R3 ctrl readback, reload reads 0", d, 16'h01);
        ticks(2);
        rd(5'h10, d); check("R5 two ticks", d, 3);
        repeat (6) @(negedge clk);
        rd(5'h10, d); check("R5 hold without tick", d, 3);
    endtask

    task automatic t_keepalive();
        logic [15:0] d;
        wr(5'h10, 16'd9);
        rd(5'h10, d); check("R2 running count not disturbed", d, 3);
        wr(5'h16, 16'h05);
        rd(5'h10, d); check("R4 keepalive reload", d, 9);
        @(negedge clk);
        bus_addr = 5'h16; bus_wdata = 16'h05; bus_wr = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
        rd(5'h10, d); check("R4 load beats tick", d, 9);
    endtask

    task automatic t_disable();
        logic [15:0] d;
        int hi = 0;
        wr(5'h10, 16'd1);
        wr(5'h16, 16'h05);
        wr(5'h16, 16'h00);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
            if (rst_out) hi++;
        end
        rd(5'h10, d); check("R6 frozen while off", d, 1);
        check("R6 no reset while off", hi, 0);
    endtask

    task automatic t_expire_nmi();
        logic [15:0] d;
        logic n1, n2;
        int hi = 0;
        wr(5'h10, 16'd1);
        wr(5'h16, 16'h0D);
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
        n1 = nmi_out;
        if (rst_out) hi++;
        @(negedge clk);
        n2 = nmi_out;
        if (rst_out) hi++;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rst_out) hi++;
        end
        check("R9 nmi pulse", n1, 1);
        check("R9 nmi one cycle", n2, 0);
        check("R8 reset width", hi, RC);
        rd(5'h10, d); check("R7 count at zero", d, 0);
        rd(5'h16, d); check("R7 warn set", d, 16'h89);
        hi = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
            if (rst_out) hi++;
        end
        check("R7 no second expiry at zero", hi, 0);
        wr(5'h16, 16'h09);
        rd(5'h16, d); check("R10 write 0 keeps warn", d, 16'h89);
    endtask

    task automatic t_warn_race();
        logic [15:0] d;
        logic n1;
        int hi = 0;
        wr(5'h10, 16'd1);
        wr(5'h16, 16'h05);
        @(negedge clk);
        bus_addr = 5'h16; bus_wdata = 16'h81; bus_wr = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
        n1 = nmi_out;
        if (rst_out) hi++;
        check("R9 no nmi when disabled", n1, 0);
        check("R8 reset on expiry", hi, 1);
        rd(5'h16, d); check("R10 expiry wins over clear", d, 16'h81);
        wr(5'h16, 16'h80);
        rd(5'h16, d); check("R10 write 1 clears warn", d, 16'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_arm_count();
        t_keepalive();
        t_disable();
        t_expire_nmi();
        t_warn_race();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule